// File: doc/BRIEF.md
# Stack-Top Arithmetic Function Unit

This block is the combinational datapath beside the data stack of a small stack-machine processor. Each cycle it sees the three topmost stack entries: the top (T, port `a_i`), the entry below it (N, port `b_i`) and the third entry (N2, port `c_i`). It also sees a 6-bit function code taken from the low bits of the instruction. From these it forms a new top value and a new second value. A per-code pop request tells the separate stack-control logic whether the stack shrinks by one.

The unit covers several groups of operations. These are arithmetic and bitwise logic, single-bit and variable shifts, and comparisons. A comparison returns a full-width flag: all ones for true and all zeros for false. Two step primitives round out the set. Run sixteen times in a loop on the T/N/N2 registers, one yields a full double-width unsigned product and the other a double-by-single unsigned division with quotient and remainder. Codes the unit does not implement leave T and N untouched.

Top module: `fu_core`

## Requirements
- R1: Code 0x10 gives y = N + T and code 0x11 gives y = N − T, both modulo 2^W. Both request a pop, and y2 = N2.
- R2: Codes 0x12, 0x13 and 0x14 give T+1, T−1 and the bitwise complement of T. They request no pop, and y2 = N.
- R3: Codes 0x15, 0x16 and 0x17 give N AND T, N OR T and N XOR T, each with a pop and y2 = N2.
- R4: Code 0x18 shifts T left by one with 0 in. 0x19 shifts it right by one with 0 in. 0x1A shifts it right by one while keeping the sign bit. None of them pops, and y2 = N.
- R5: Code 0x1B gives N shifted right logically by T bit positions, and 0x1C gives N shifted left by T positions. A shift amount of W or more gives 0. Both pop, and y2 = N2.
- R6: Code 0x1D (multiply step) forms the W+1-bit sum S = T + (N[0] ? N2 : 0). It gives y = S[W:1] and y2 = {S[0], N[W-1:1]}, with no pop.
- R7: Code 0x1E (divide step) forms V = {T, N[W-1]} and sets y2 = {N[W-2:0], 0}. When V ≥ N2, V becomes V − N2 and y2[0] is set. y = V[W-1:0], with no pop.
- R8: Code 0x20 gives all ones and 0x21 gives all zeros. 0x22 gives all ones exactly when T is zero. 0x23 gives all ones exactly when T[W-1] is set. None of them pops, and y2 = N.
- R9: Codes 0x24 to 0x29 compare N against T as unsigned numbers, in order: N>T, N<T, N=T, N≥T, N≤T, N≠T. Each gives all ones when true and all zeros when false, pops, and sets y2 = N2.
- R10: Codes 0x2A to 0x2D compare N against T as two's-complement numbers, in order: N>T, N<T, N≥T, N≤T. Each gives a full-width flag, pops, and sets y2 = N2.
- R11: pop_o is 1 for exactly the codes 0x10, 0x11, 0x15–0x17, 0x1B, 0x1C and 0x24–0x2D, and 0 for every other code.
- R12: Every code outside 0x10–0x1E and 0x20–0x2D gives y = T and y2 = N with no pop.
- R13: Start with T = 0, N = u2 and N2 = u1, then apply code 0x1D sixteen times, feeding y back to T and y2 to N. At W = 16 this leaves {T, N} = u1 × u2.
- R14: Start with T = high half, N = low half and N2 = divisor, with the high half below the divisor, then apply code 0x1E sixteen times the same way. At W = 16 this leaves T = remainder and N = quotient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Top-of-stack value T |
| b_i | input | W | Second stack entry N |
| c_i | input | W | Third stack entry N2 |
| code_i | input | 6 | Function code (low opcode bits) |
| y_o | output | W | New top-of-stack value |
| y2_o | output | W | New second-entry value |
| pop_o | output | 1 | Request for the stack control to pop one entry |

## Verification
Every result of this unit is due in the same cycle as its inputs, zero register stages away. The bench drives a new operand set and function code, lets it settle, and compares within the same clock phase, well clear of any clock edge. For the looped multiply and divide, each step's outputs are captured and fed back before the next step is driven, so one iteration costs exactly one settle interval. The final pair is compared only after the sixteenth step.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int DATA_W = 16;
    localparam int CODE_W = 6;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD   = 6'h10,
        OP_SUB   = 6'h11,
        OP_INC   = 6'h12,
        OP_DEC   = 6'h13,
        OP_NOT   = 6'h14,
        OP_AND   = 6'h15,
        OP_OR    = 6'h16,
        OP_XOR   = 6'h17,
        OP_SHL1  = 6'h18,
        OP_SHR1  = 6'h19,
        OP_ASR1  = 6'h1A,
        OP_SHRV  = 6'h1B,
        OP_SHLV  = 6'h1C,
        OP_MSTEP = 6'h1D,
        OP_DSTEP = 6'h1E,
        OP_ONES  = 6'h20,
        OP_ZERO  = 6'h21,
        OP_EQZ   = 6'h22,
        OP_NEG   = 6'h23,
        OP_UGT   = 6'h24,
        OP_ULT   = 6'h25,
        OP_EQ    = 6'h26,
        OP_UGE   = 6'h27,
        OP_ULE   = 6'h28,
        OP_NE    = 6'h29,
        OP_SGT   = 6'h2A,
        OP_SLT   = 6'h2B,
        OP_SGE   = 6'h2C,
        OP_SLE   = 6'h2D
    } fcode_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ALU  = 2'd1,
        CLS_STEP = 2'd2,
        CLS_FLAG = 2'd3
    } fclass_e;

    function automatic fclass_e op_class(input logic [CODE_W-1:0] code);
        if (code >= 6'h10 && code <= 6'h1C)      return CLS_ALU;
        else if (code == 6'h1D || code == 6'h1E) return CLS_STEP;
        else if (code >= 6'h20 && code <= 6'h2D) return CLS_FLAG;
        else                                     return CLS_NONE;
    endfunction

    function automatic logic op_pops(input logic [CODE_W-1:0] code);
        case (code)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHRV, OP_SHLV: return 1'b1;
            default: return (code >= 6'h24 && code <= 6'h2D);
        endcase
    endfunction

endpackage

// File: rtl/fu_alu.sv
module fu_alu #(
    parameter int W = fu_pkg::DATA_W
) (
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    input  logic [fu_pkg::CODE_W-1:0] code_i,
    output logic [W-1:0]              y_o
);
    import fu_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] shr_v;
    logic [W-1:0] shl_v;

    // Variable shifts: amounts of W or more drain every bit out.
    assign shr_v = b_i >> a_i;
    assign shl_v = b_i << a_i;

    always_comb begin
        case (fcode_e'(code_i))
            OP_ADD:  y_o = b_i + a_i;
            OP_SUB:  y_o = b_i - a_i;
            OP_INC:  y_o = a_i + ONE;
            OP_DEC:  y_o = a_i - ONE;
            OP_NOT:  y_o = ~a_i;
            OP_AND:  y_o = b_i & a_i;
            OP_OR:   y_o = b_i | a_i;
            OP_XOR:  y_o = b_i ^ a_i;
            OP_SHL1: y_o = {a_i[W-2:0], 1'b0};
            OP_SHR1: y_o = {1'b0, a_i[W-1:1]};
            OP_ASR1: y_o = {a_i[W-1], a_i[W-1:1]};
            OP_SHRV: y_o = shr_v;
            OP_SHLV: y_o = shl_v;
            default: y_o = a_i;
        endcase
    end

endmodule

// File: rtl/fu_step.sv
module fu_step #(
    parameter int W = fu_pkg::DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    input  logic         div_i,
    output logic [W-1:0] y_o,
    output logic [W-1:0] y2_o
);
    localparam int XW = W + 1;

    logic [XW-1:0] mul_sum;
    logic [XW-1:0] div_cat;
    logic [XW-1:0] div_sub;
    logic          div_fit;

    // Multiply step: conditional add, then shift the pair right by one.
    assign mul_sum = {1'b0, a_i} + (b_i[0] ? {1'b0, c_i} : '0);

    // Divide step: shift the pair left by one, then conditional subtract.
    assign div_cat = {a_i, b_i[W-1]};
    assign div_fit = (div_cat >= {1'b0, c_i});
    assign div_sub = div_cat - {1'b0, c_i};

    always_comb begin
        if (div_i) begin
            y_o  = div_fit ? div_sub[W-1:0] : div_cat[W-1:0];
            y2_o = {b_i[W-2:0], div_fit};
        end else begin
            y_o  = mul_sum[XW-1:1];
            y2_o = {mul_sum[0], b_i[W-1:1]};
        end
    end

endmodule

// File: rtl/fu_cmp.sv
module fu_cmp #(
    parameter int W = fu_pkg::DATA_W
) (
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    input  logic [fu_pkg::CODE_W-1:0] code_i,
    output logic [W-1:0]              flag_o
);
    import fu_pkg::*;

    logic u_gt, u_lt, eq, s_gt, s_lt, cond;

    assign eq   = (b_i == a_i);
    assign u_gt = (b_i > a_i);
    assign u_lt = (b_i < a_i);
    assign s_gt = ($signed(b_i) > $signed(a_i));
    assign s_lt = ($signed(b_i) < $signed(a_i));

    always_comb begin
        case (fcode_e'(code_i))
            OP_ONES: cond = 1'b1;
            OP_ZERO: cond = 1'b0;
            OP_EQZ:  cond = (a_i == '0);
            OP_NEG:  cond = a_i[W-1];
            OP_UGT:  cond = u_gt;
            OP_ULT:  cond = u_lt;
            OP_EQ:   cond = eq;
            OP_UGE:  cond = !u_lt;
            OP_ULE:  cond = !u_gt;
            OP_NE:   cond = !eq;
            OP_SGT:  cond = s_gt;
            OP_SLT:  cond = s_lt;
            OP_SGE:  cond = !s_lt;
            OP_SLE:  cond = !s_gt;
            default: cond = 1'b0;
        endcase
    end

    assign flag_o = {W{cond}};

endmodule

// File: rtl/fu_core.sv
module fu_core #(
    parameter int W = fu_pkg::DATA_W
) (
    input  logic [W-1:0]              a_i,
    input  logic [W-1:0]              b_i,
    input  logic [W-1:0]              c_i,
    input  logic [fu_pkg::CODE_W-1:0] code_i,
    output logic [W-1:0]              y_o,
    output logic [W-1:0]              y2_o,
    output logic                      pop_o
);
    import fu_pkg::*;

    fclass_e      cls;
    logic [W-1:0] alu_y;
    logic [W-1:0] step_y;
    logic [W-1:0] step_y2;
    logic [W-1:0] flag_y;

    assign cls = op_class(code_i);

    fu_alu #(.W(W)) u_alu (
        .a_i(a_i), .b_i(b_i), .code_i(code_i), .y_o(alu_y)
    );

    fu_step #(.W(W)) u_step (
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .div_i(code_i == OP_DSTEP),
        .y_o(step_y), .y2_o(step_y2)
    );

    fu_cmp #(.W(W)) u_cmp (
        .a_i(a_i), .b_i(b_i), .code_i(code_i), .flag_o(flag_y)
    );

    always_comb begin
        pop_o = op_pops(code_i);
        case (cls)
            CLS_ALU:  y_o = alu_y;
            CLS_STEP: y_o = step_y;
            CLS_FLAG: y_o = flag_y;
            default:  y_o = a_i;
        endcase
        if (pop_o)              y2_o = c_i;
        else if (cls == CLS_STEP) y2_o = step_y2;
        else                    y2_o = b_i;
    end

    always_comb begin
        if (code_i == OP_ADD)
            p_add_inverse_r1: assert (y_o - a_i == b_i) else $error("add inverse");
        if (code_i == OP_SUB)
            p_sub_inverse_r1: assert (y_o + a_i == b_i) else $error("sub inverse");
        if (code_i == OP_SHL1)
            p_shl_lsb_r4: assert (y_o[0] == 1'b0 && (y_o >> 1) == {1'b0, a_i[W-2:0]})
                else $error("shl1");
        if (code_i == OP_MSTEP && !b_i[0])
            p_mstep_skip_r6: assert (y_o == (a_i >> 1)) else $error("mstep no add");
        if (code_i == OP_DSTEP)
            p_dstep_shift_r7: assert (y2_o[W-1:1] == b_i[W-2:0]) else $error("dstep shift");
        if (code_i >= 6'h24 && code_i <= 6'h29)
            p_uflag_full_r9: assert ($countones(y_o) == 0 || $countones(y_o) == W)
                else $error("flag width");
        if (code_i >= 6'h2A && code_i <= 6'h2D)
            p_sflag_full_r10: assert (y_o == '0 || y_o == '1) else $error("sflag width");
        if (pop_o)
            p_pop_known_r11: assert (cls == CLS_ALU || cls == CLS_FLAG) else $error("pop class");
        if (cls == CLS_NONE)
            p_unknown_pass_r12: assert (y_o == a_i && y2_o == b_i && !pop_o)
                else $error("pass-through");
    end

endmodule

// File: tb/fu_core_bench.sv
`timescale 1ns/100ps
module fu_core_bench;

    localparam int WL = 16;
    localparam int WS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    logic [WL-1:0] a, b, c, y, y2;
    logic [5:0]    code;
    logic          pop;
    logic [WS-1:0] sa, sb, sc, sy, sy2;
    logic [5:0]    scode;
    logic          spop;

    fu_core #(.W(WL)) u_fu_core (
        .a_i(a), .b_i(b), .c_i(c), .code_i(code),
        .y_o(y), .y2_o(y2), .pop_o(pop)
    );

    fu_core #(.W(WS)) u_fu_core_s (
        .a_i(sa), .b_i(sb), .c_i(sc), .code_i(scode),
        .y_o(sy), .y2_o(sy2), .pop_o(spop)
    );

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic void model(input int op, input int ta, input int tb, input int tc,
                                  output int ey, output int ey2, output bit ep,
                                  output string tag);
        int s;
        ey = ta; ey2 = tb; ep = 1'b0; tag = "R12";
        case (op)
            'h10: begin ey = (tb + ta) & 15; ep = 1; tag = "R1"; end
            'h11: begin ey = (tb - ta) & 15; ep = 1; tag = "R1"; end
            'h12: begin ey = (ta + 1) & 15; tag = "R2"; end
            'h13: begin ey = (ta - 1) & 15; tag = "R2"; end
            'h14: begin ey = (~ta) & 15; tag = "R2"; end
            'h15: begin ey = tb & ta; ep = 1; tag = "R3"; end
            'h16: begin ey = tb | ta; ep = 1; tag = "R3"; end
            'h17: begin ey = tb ^ ta; ep = 1; tag = "R3"; end
            'h18: begin ey = (ta << 1) & 15; tag = "R4"; end
            'h19: begin ey = ta >> 1; tag = "R4"; end
            'h1A: begin ey = (ta >> 1) | (ta & 8); tag = "R4"; end
            'h1B: begin ey = (ta >= 4) ? 0 : (tb >> ta); ep = 1; tag = "R5"; end
            'h1C: begin ey = (ta >= 4) ? 0 : ((tb << ta) & 15); ep = 1; tag = "R5"; end
            'h1D: begin
                s = ta + ((tb & 1) ? tc : 0);
                ey = s >> 1; ey2 = ((s & 1) << 3) | (tb >> 1); tag = "R6";
            end
            'h1E: begin
                s = (ta << 1) | (tb >> 3);
                ey2 = (tb << 1) & 15;
                if (s >= tc) begin s = s - tc; ey2 = ey2 | 1; end
                ey = s & 15; tag = "R7";
            end
            'h20: begin ey = 15; tag = "R8"; end
            'h21: begin ey = 0;  tag = "R8"; end
            'h22: begin ey = (ta == 0) ? 15 : 0; tag = "R8"; end
            'h23: begin ey = (ta & 8) ? 15 : 0; tag = "R8"; end
            'h24: begin ey = (tb >  ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h25: begin ey = (tb <  ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h26: begin ey = (tb == ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h27: begin ey = (tb >= ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h28: begin ey = (tb <= ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h29: begin ey = (tb != ta) ? 15 : 0; ep = 1; tag = "R9"; end
            'h2A: begin ey = (sx(tb) >  sx(ta)) ? 15 : 0; ep = 1; tag = "R10"; end
            'h2B: begin ey = (sx(tb) <  sx(ta)) ? 15 : 0; ep = 1; tag = "R10"; end
            'h2C: begin ey = (sx(tb) >= sx(ta)) ? 15 : 0; ep = 1; tag = "R10"; end
            'h2D: begin ey = (sx(tb) <= sx(ta)) ? 15 : 0; ep = 1; tag = "R10"; end
            default: ;
        endcase
        if (ep) ey2 = tc;
    endfunction

    task automatic mul_run(input logic [WL-1:0] u1, input logic [WL-1:0] u2);
        a = '0; b = u2; c = u1; code = 6'h1D;
        for (int i = 0; i < 16; i++) begin
            #0.4;
            a = y; b = y2;
            #0.6;
        end
        chk("R13", {a, b}, longint'(u1) * longint'(u2));
    endtask

    task automatic div_run(input logic [31:0] num, input logic [WL-1:0] d);
        a = num[31:16]; b = num[15:0]; c = d; code = 6'h1E;
        for (int i = 0; i < 16; i++) begin
            #0.4;
            a = y; b = y2;
            #0.6;
        end
        chk("R14", b, num / d);
        chk("R14", a, num % d);
    endtask

    initial begin
        while (cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_err++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int ey, ey2;
        bit ep;
        string tag;
        a = '0; b = '0; c = '0; code = '0;
        sa = '0; sb = '0; sc = '0; scode = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Quiet start: code 0 with zero operands passes zeros (R12).
        chk("R12", y, 0);
        chk("R12", y2, 0);
        chk("R11", pop, 0);

        // Exhaustive sweep of the 4-bit configuration.
        for (int op = 0; op < 64; op++) begin
            for (int ta = 0; ta < 16; ta++) begin
                for (int tb = 0; tb < 16; tb++) begin
                    for (int tc = 0; tc < 16; tc++) begin
                        scode = 6'(op); sa = 4'(ta); sb = 4'(tb); sc = 4'(tc);
                        #0.4;
                        model(op, ta, tb, tc, ey, ey2, ep, tag);
                        chk(tag, sy, ey);
                        chk(tag, sy2, ey2);
                        chk("R11", spop, ep);
                        #0.6;
                    end
                end
            end
        end

        // Full-width spot checks of edge behaviour.
        a = 16'd16; b = 16'hFFFF; c = 16'h1234; code = 6'h1B; #0.4;
        chk("R5", y, 0); chk("R5", y2, 16'h1234); #0.6;
        a = 16'd15; code = 6'h1C; #0.4;
        chk("R5", y, 16'h8000); #0.6;
        a = 16'h0001; b = 16'h8000; code = 6'h2A; #0.4;
        chk("R10", y, 0); #0.6;
        code = 6'h24; #0.4;
        chk("R9", y, 16'hFFFF); #0.6;

        mul_run(16'hFFFF, 16'hFFFF);
        mul_run(16'd1234, 16'd5678);
        mul_run(16'h0000, 16'h8001);
        mul_run(16'hABCD, 16'h0003);

        div_run(32'h0001_2345, 16'h0100);
        div_run(32'hFFFE_FFFF, 16'hFFFF);
        div_run(32'h0000_0007, 16'h0003);
        div_run(32'h1234_5678, 16'h8000);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule